// File: doc/BRIEF.md
# Looping SPI register slave

This block is a mode-0 SPI slave in front of a ten-byte register space. Six of those bytes are read-only and hold the latest results of two conversion channels. The other four are read/write configuration bytes: phase, gain, a status/command byte and a format byte. SCK, CS and SDI are brought into the system clock domain through two-flop synchronisers, so SCK must run well below the system clock.

Every transaction opens with one control byte that carries a 7-bit address and a direction flag. After that byte, data flows one byte after another for as long as CS stays low. Between bytes an internal address counter moves on. When reading, it follows one of four loop modes taken from the status byte. It also steps over the low byte of any channel that is set to 16-bit format, so a single control byte can sustain an endless stream of samples.

A result strobe loads both channel words. When the counter arrives at a channel's upper byte, that channel's whole word is frozen into a shadow, so every byte of one read comes from the same sample.

Top module: `spi_loop_slave`

## Requirements
- R1: SDI is sampled on rising SCK edges and SDO changes only after falling edges, with SCK idle low. Each data byte goes out MSB first, and its first bit appears after the falling edge that follows the last bit of the previous byte.
- R2: The control byte is made of address bits 6..0, MSB first, followed by a direction bit: 1 reads and 0 writes. No further control byte is used in the transaction.
- R3: `sdo_en_o` is 0 while CS is high, during the control byte and throughout a write. It is 1 while read data is being shifted out.
- R4: Raising CS ends the transaction at any bit and clears the shift state. The next CS low period starts again with a control byte.
- R5: Bits [1:0] of the status byte at address 8 select the read loop mode. Value 0 holds the address, so the same byte repeats.
- R6: Loop mode 1 wraps inside the groups {0..2}, {3..5}, {6..7} and {8..9}.
- R7: Loop mode 2 wraps inside the types {0..5} and {6..9}. Loop mode 3 wraps over the whole map 0..9. Mode 2 is the reset value.
- R8: Channel 0 occupies addresses 0, 1 and 2 (upper, middle, lower) and channel 1 occupies 3, 4 and 5. Bit 0 of the format byte at address 9 sets the channel 0 width and bit 1 sets the channel 1 width, with 1 meaning 24-bit. A width of 0 makes the read counter skip that channel's lower byte.
- R9: When a read loads address 0 or 3, the upper byte comes from the live result and the whole word is copied to that channel's shadow. Middle and lower bytes are always read from the shadow.
- R10: A one-cycle `res_valid_i` pulse loads both `res_ch0_i` and `res_ch1_i` as the live results.
- R11: Each write byte goes to the current address, and the counter then steps and wraps inside that address's type. Writes to addresses 0..5 change nothing.
- R12: After reset, phase and gain are 0x00, status is 0x02, format is 0x03, the results are zero and `sdo_en_o` is 0.
- R13: Addresses 10..127 read as 0x00, keep the counter where it is and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples SCK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI clock, idles low |
| sdi_i | input | 1 | Serial data into the slave |
| sdo_o | output | 1 | Serial data out of the slave |
| sdo_en_o | output | 1 | Drive enable for the SDO pad; 0 means high impedance |
| res_valid_i | input | 1 | One-cycle strobe for a new pair of results |
| res_ch0_i | input | 24 | Channel 0 result word |
| res_ch1_i | input | 24 | Channel 1 result word |
| phase_o | output | 8 | Phase configuration byte |
| gain_o | output | 8 | Gain configuration byte |

## Verification
SCK, CS and SDI each pass two synchroniser flops and an edge-detect flop, and SDO comes from a register. A new SDO bit is therefore valid about four system clocks after the SCK falling edge. The bench holds each SCK phase for eight clocks and samples SDO and `sdo_en_o` on the last clock of the low phase, just before it raises SCK. The expected byte comes from a behavioural model of the map, the shadows and the counter, evaluated at the byte boundary where the design loads it. The per-clock enable check only starts six clocks after CS rises, and configuration outputs are compared once the transaction has closed.

// File: rtl/spi_loop_pkg.sv
package spi_loop_pkg;
  localparam int ADDR_W    = 7;
  localparam int BYTE_W    = 8;
  localparam int RES_W     = 24;
  localparam int RES_BYTES = RES_W / BYTE_W;
  localparam int CH_N      = 2;
  localparam int CFG_N     = 4;

  localparam logic [ADDR_W-1:0] A_CH0_LO = ADDR_W'(RES_BYTES - 1);
  localparam logic [ADDR_W-1:0] A_CH1_LO = ADDR_W'(2 * RES_BYTES - 1);
  localparam logic [ADDR_W-1:0] A_PHASE  = ADDR_W'(CH_N * RES_BYTES);
  localparam logic [ADDR_W-1:0] A_STAT   = A_PHASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LAST   = A_PHASE + ADDR_W'(CFG_N - 1);

  localparam logic [BYTE_W-1:0] STAT_RST = 8'h02;
  localparam logic [BYTE_W-1:0] FMT_RST  = 8'h03;

  typedef enum logic [1:0] {
    LOOP_HOLD  = 2'd0,
    LOOP_GROUP = 2'd1,
    LOOP_TYPE  = 2'd2,
    LOOP_ALL   = 2'd3
  } loop_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } span_t;

  function automatic span_t type_span(input logic [ADDR_W-1:0] a);
    span_t s;
    if (a < A_PHASE) begin
      s.lo = '0;
      s.hi = A_PHASE - ADDR_W'(1);
    end else begin
      s.lo = A_PHASE;
      s.hi = A_LAST;
    end
    return s;
  endfunction

  function automatic span_t group_span(input logic [ADDR_W-1:0] a);
    span_t s;
    if (a <= A_CH0_LO) begin
      s.lo = '0;
      s.hi = A_CH0_LO;
    end else if (a <= A_CH1_LO) begin
      s.lo = A_CH0_LO + ADDR_W'(1);
      s.hi = A_CH1_LO;
    end else if (a < A_STAT) begin
      s.lo = A_PHASE;
      s.hi = A_STAT - ADDR_W'(1);
    end else begin
      s.lo = A_STAT;
      s.hi = A_LAST;
    end
    return s;
  endfunction
endpackage

// File: rtl/spi_loop_sync.sv
module spi_loop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_n_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sdi_o
);
  logic [STAGES-1:0] cs_p, sck_p, sdi_p;
  logic              sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_p  <= '1;
      sck_p <= '0;
      sdi_p <= '0;
      sck_d <= 1'b0;
    end else begin
      cs_p  <= {cs_p[STAGES-2:0], cs_ni};
      sck_p <= {sck_p[STAGES-2:0], sck_i};
      sdi_p <= {sdi_p[STAGES-2:0], sdi_i};
      sck_d <= sck_p[STAGES-1];
    end
  end

  assign cs_n_o     = cs_p[STAGES-1];
  assign sdi_o      = sdi_p[STAGES-1];
  assign sck_rise_o = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_p[STAGES-1] & sck_d;
endmodule

// File: rtl/spi_loop_addr.sv
module spi_loop_addr
  import spi_loop_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              read_i,
  input  loop_mode_e        mode_i,
  input  logic [CH_N-1:0]   width_i,
  output logic [ADDR_W-1:0] next_o
);
  span_t             sp;
  logic [ADDR_W-1:0] step1, step2;
  logic              skip;

  always_comb begin
    if (!read_i) sp = type_span(addr_i);
    else begin
      unique case (mode_i)
        LOOP_GROUP: sp = group_span(addr_i);
        LOOP_TYPE:  sp = type_span(addr_i);
        default: begin
          sp.lo = '0;
          sp.hi = A_LAST;
        end
      endcase
    end
    step1 = (addr_i == sp.hi) ? sp.lo : addr_i + ADDR_W'(1);
    step2 = (step1 == sp.hi) ? sp.lo : step1 + ADDR_W'(1);
    skip  = read_i && ((step1 == A_CH0_LO && !width_i[0]) ||
                       (step1 == A_CH1_LO && !width_i[1]));
    if (addr_i > A_LAST)                      next_o = addr_i;
    else if (read_i && mode_i == LOOP_HOLD)   next_o = addr_i;
    else                                      next_o = skip ? step2 : step1;
  end
endmodule

// File: rtl/spi_loop_regfile.sv
module spi_loop_regfile
  import spi_loop_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           res_valid_i,
  input  logic [CH_N-1:0][RES_W-1:0]     res_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  input  logic                           cap_i,
  output logic [BYTE_W-1:0]              rd_data_o,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [BYTE_W-1:0]              wr_data_i,
  output loop_mode_e                     mode_o,
  output logic [CH_N-1:0]                width_o,
  output logic [BYTE_W-1:0]              phase_o,
  output logic [BYTE_W-1:0]              gain_o
);
  logic [RES_W-1:0]  live_q   [CH_N];
  logic [RES_W-1:0]  shadow_q [CH_N];
  logic [BYTE_W-1:0] cfg_q    [CFG_N];

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * RES_BYTES);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[c]   <= '0;
        shadow_q[c] <= '0;
      end else begin
        if (res_valid_i) live_q[c] <= res_i[c];
        if (cap_i && rd_addr_i == BASE) shadow_q[c] <= live_q[c];
      end
    end
    AST_SHADOW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cap_i && rd_addr_i == BASE) |=> $stable(shadow_q[c])); // R9
  end

  for (genvar r = 0; r < CFG_N; r++) begin : g_cfg
    localparam logic [ADDR_W-1:0] AR = A_PHASE + ADDR_W'(r);
    localparam logic [BYTE_W-1:0] RV = (AR == A_STAT) ? STAT_RST :
                                       (AR == A_LAST) ? FMT_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[r] <= RV;
      else if (wr_en_i && wr_addr_i == AR) cfg_q[r] <= wr_data_i;
    end
    AST_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(cfg_q[r])); // R11
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < CH_N; c++) begin
      for (int b = 0; b < RES_BYTES; b++) begin
        if (rd_addr_i == ADDR_W'(c * RES_BYTES + b))
          rd_data_o = (b == 0) ? live_q[c][RES_W-1 -: BYTE_W]
                               : shadow_q[c][RES_W-1-BYTE_W*b -: BYTE_W];
      end
    end
    for (int r = 0; r < CFG_N; r++) begin
      if (rd_addr_i == A_PHASE + ADDR_W'(r)) rd_data_o = cfg_q[r];
    end
  end

  assign phase_o = cfg_q[0];
  assign gain_o  = cfg_q[1];
  assign mode_o  = loop_mode_e'(cfg_q[2][1:0]);
  assign width_o = cfg_q[3][CH_N-1:0];
endmodule

// File: rtl/spi_loop_slave.sv
module spi_loop_slave
  import spi_loop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  input  logic              res_valid_i,
  input  logic [RES_W-1:0]  res_ch0_i,
  input  logic [RES_W-1:0]  res_ch1_i,
  output logic [BYTE_W-1:0] phase_o,
  output logic [BYTE_W-1:0] gain_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic cs_n_s, sck_rise, sck_fall, sdi_s;

  logic              in_data_q, rw_q, sdo_q, oe_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] rx_q, tx_q, rx_nxt, rd_data;
  logic [ADDR_W-1:0] addr_q, nxt_addr, load_addr;
  logic              byte_done, ctrl_done, data_done, rd_load, wr_en;
  loop_mode_e        mode;
  logic [CH_N-1:0]   width;

  spi_loop_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .sdi_i,
    .cs_n_o(cs_n_s), .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sdi_o(sdi_s)
  );

  spi_loop_addr i_addr (
    .addr_i(addr_q), .read_i(rw_q), .mode_i(mode), .width_i(width), .next_o(nxt_addr)
  );

  spi_loop_regfile i_regs (
    .clk_i, .rst_ni,
    .res_valid_i,
    .res_i({res_ch1_i, res_ch0_i}),
    .rd_addr_i(load_addr), .cap_i(rd_load), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(addr_q), .wr_data_i(rx_nxt),
    .mode_o(mode), .width_o(width), .phase_o, .gain_o
  );

  assign rx_nxt    = {rx_q[BYTE_W-2:0], sdi_s};
  assign byte_done = sck_rise && !cs_n_s && (bit_q == BIT_W'(BYTE_W - 1));
  assign ctrl_done = byte_done && !in_data_q;
  assign data_done = byte_done && in_data_q;
  // control byte: address in [7:1], read flag in [0]
  assign load_addr = in_data_q ? nxt_addr : rx_nxt[BYTE_W-1:1];
  assign rd_load   = (ctrl_done && rx_nxt[0]) || (data_done && rw_q);
  assign wr_en     = data_done && !rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_q <= 1'b0;
      rw_q      <= 1'b0;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else if (cs_n_s) begin
      in_data_q <= 1'b0;
      rw_q      <= 1'b0;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_q  <= rx_nxt;
        bit_q <= bit_q + BIT_W'(1);
      end
      if (ctrl_done) begin
        in_data_q <= 1'b1;
        rw_q      <= rx_nxt[0];
        addr_q    <= rx_nxt[BYTE_W-1:1];
      end
      if (data_done) addr_q <= nxt_addr;
      if (rd_load)   tx_q   <= rd_data;
      if (sck_fall && in_data_q && rw_q) begin
        sdo_q <= tx_q[BYTE_W-1];
        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        oe_q  <= 1'b1;
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = oe_q;

  AST_OE_OFF_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> !oe_q); // R3
  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_data_q || !rw_q) |-> !oe_q); // R3
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_done && rw_q && mode == LOOP_HOLD) |=> addr_q == $past(addr_q)); // R5
  AST_IN_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_done && addr_q <= A_LAST) |=> addr_q <= A_LAST); // R7
  AST_SKIP_CH0_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_done && rw_q && mode != LOOP_HOLD && !width[0] && addr_q <= A_LAST)
      |=> addr_q != A_CH0_LO); // R8
  AST_WR_IN_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_done && !rw_q && addr_q >= A_PHASE && addr_q <= A_LAST)
      |=> (addr_q >= A_PHASE && addr_q <= A_LAST)); // R11
endmodule

// File: tb/test_spi_loop_slave.sv
module test_spi_loop_slave;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en, res_valid = 1'b0;
  logic [23:0] res0 = '0, res1 = '0;
  logic [7:0] phase, gain;

  always #10 clk = ~clk;

  spi_loop_slave i_spi_loop_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .res_valid_i(res_valid),
    .res_ch0_i(res0), .res_ch1_i(res1), .phase_o(phase), .gain_o(gain)
  );

  int n_chk = 0, n_bad = 0, cs_hi_cnt = 0;
  logic [23:0] m_live0 = '0, m_live1 = '0, m_sh0 = '0, m_sh1 = '0;
  logic [7:0]  m_cfg [4];
  logic [7:0]  wbuf [16];
  logic [23:0] upd0, upd1;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input int a);
    case (a)
      0: begin m_sh0 = m_live0; return m_live0[23:16]; end
      1: return m_sh0[15:8];
      2: return m_sh0[7:0];
      3: begin m_sh1 = m_live1; return m_live1[23:16]; end
      4: return m_sh1[15:8];
      5: return m_sh1[7:0];
      6, 7, 8, 9: return m_cfg[a-6];
      default: return 8'h00;
    endcase
  endfunction

  function automatic int m_next(input int a, input bit rd);
    int lo, hi, n, mode;
    if (a > 9) return a;
    mode = rd ? int'(m_cfg[2][1:0]) : 2;
    if (mode == 0) return a;
    if (mode == 1) begin
      if (a <= 2) begin lo = 0; hi = 2; end
      else if (a <= 5) begin lo = 3; hi = 5; end
      else if (a <= 7) begin lo = 6; hi = 7; end
      else begin lo = 8; hi = 9; end
    end else if (mode == 2) begin
      if (a <= 5) begin lo = 0; hi = 5; end else begin lo = 6; hi = 9; end
    end else begin lo = 0; hi = 9; end
    n = (a == hi) ? lo : a + 1;
    if (rd && ((n == 2 && !m_cfg[3][0]) || (n == 5 && !m_cfg[3][1])))
      n = (n == hi) ? lo : n + 1;
    return n;
  endfunction

  task automatic pulse_res(input logic [23:0] a, input logic [23:0] b);
    @(negedge clk);
    res0 = a; res1 = b; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    m_live0 = a; m_live1 = b;
  endtask

  task automatic bit_xfer(input logic d, output logic q, output logic oe);
    sdi = d;
    repeat (HALF) @(negedge clk);
    q = sdo; oe = sdo_en;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xact(input string tag, input int addr, input bit rd,
                      input int nbytes, input int upd_byte);
    logic [7:0] cmd, exp, wd;
    logic q, oe;
    int cur;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    cmd = {addr[6:0], rd};
    for (int i = 0; i < 8; i++) begin
      bit_xfer(cmd[7-i], q, oe);
      chk("R3 ctrl oe", {31'd0, oe}, 32'd0);
    end
    cur = addr;
    for (int b = 0; b < nbytes; b++) begin
      exp = rd ? m_read(cur) : 8'h00;
      wd  = wbuf[b];
      for (int i = 0; i < 8; i++) begin
        if (rd && b == upd_byte && i == 1) pulse_res(upd0, upd1);
        bit_xfer(rd ? 1'b0 : wd[7-i], q, oe);
        if (rd) begin
          chk(tag, {31'd0, q}, {31'd0, exp[7-i]});
          chk("R3 read oe", {31'd0, oe}, 32'd1);
        end else chk("R3 write oe", {31'd0, oe}, 32'd0);
      end
      if (!rd && cur >= 6 && cur <= 9) m_cfg[cur-6] = wd;
      cur = m_next(cur, rd);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R3 idle oe", {31'd0, sdo_en}, 32'd0);
  endtask

  always @(negedge clk) begin
    cs_hi_cnt = cs_n ? cs_hi_cnt + 1 : 0;
    if (rst_n && !done && cs_hi_cnt >= 6) chk("R3 cs high", {31'd0, sdo_en}, 32'd0);
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic q, oe;
    m_cfg[0] = 8'h00; m_cfg[1] = 8'h00; m_cfg[2] = 8'h02; m_cfg[3] = 8'h03;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 oe", {31'd0, sdo_en}, 32'd0);
    chk("R12 phase", {24'd0, phase}, 32'h00);
    chk("R12 gain", {24'd0, gain}, 32'h00);
    xact("R12 R7 type loop cfg", 8, 1, 5, -1);
    xact("R12 zero results", 0, 1, 3, -1);

    pulse_res(24'hA1B2C3, 24'hD4E5F6);
    xact("R1 R8 both channels", 0, 1, 8, -1);
    xact("R10 live results", 3, 1, 3, -1);

    wbuf[0] = 8'h5A; wbuf[1] = 8'h3C; wbuf[2] = 8'h01; wbuf[3] = 8'h03; wbuf[4] = 8'h77;
    xact("R2 write", 6, 0, 5, -1);
    chk("R11 phase after wrap", {24'd0, phase}, 32'h77);
    chk("R11 gain", {24'd0, gain}, 32'h3C);

    xact("R6 group ch1", 3, 1, 5, -1);
    xact("R6 group cfg", 6, 1, 3, -1);
    xact("R2 read status", 8, 1, 1, -1);

    wbuf[0] = 8'h01;
    xact("R2 write fmt", 9, 0, 1, -1);
    xact("R8 ch1 16-bit skip", 3, 1, 5, -1);

    wbuf[0] = 8'h03;
    xact("R2 write status", 8, 0, 1, -1);
    xact("R7 whole map loop", 8, 1, 11, -1);

    wbuf[0] = 8'h00;
    xact("R2 write status", 8, 0, 1, -1);
    xact("R5 hold", 1, 1, 3, -1);

    wbuf[0] = 8'h02; wbuf[1] = 8'h00;
    xact("R2 write status fmt", 8, 0, 2, -1);
    xact("R8 both 16-bit type loop", 0, 1, 6, -1);
    wbuf[0] = 8'h03;
    xact("R2 write fmt", 9, 0, 1, -1);
    upd0 = 24'h112233; upd1 = 24'h445566;
    xact("R9 coherent shadow", 0, 1, 6, 1);
    xact("R10 new sample", 0, 1, 3, -1);

    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    xact("R11 write data ignored", 0, 0, 2, -1);
    xact("R11 data unchanged", 0, 1, 3, -1);

    xact("R13 out of map read", 7'h50, 1, 3, -1);
    wbuf[0] = 8'hAA;
    xact("R13 out of map write", 7'h50, 0, 1, -1);
    xact("R13 cfg unchanged", 6, 1, 4, -1);
    chk("R13 phase", {24'd0, phase}, 32'h77);

    // R4: abort in the middle of a read byte
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) bit_xfer((i == 4 || i == 7) ? 1'b1 : 1'b0, q, oe);
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, q, oe);
    chk("R4 oe before abort", {31'd0, oe}, 32'd1);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R4 oe after abort", {31'd0, sdo_en}, 32'd0);
    xact("R4 fresh control byte", 9, 1, 3, -1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule